// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset or NMI Action

This block is a watchdog peripheral for a small CPU subsystem. Software reaches it through a byte-wide register port with an address, a write strobe, a read strobe, write data and combinational read data. A control register at address 0x93 holds the enable, the time-out action, the count-source select and the period select. It also shows two read-only flags: one for the cause of the last reset and one for the source of an NMI. A restart register at address 0x94 clears the running count, but only when it receives a two-byte key.

Once software enables the counter, it cannot turn it off again without a reset. The counter advances on the system clock or on rising edges of a slow real-time-clock input. That input is asynchronous, so the block passes it through a two-flop synchronizer and an edge detector. When the count reaches its terminal value, the block takes one of two actions. It either holds a reset request for four system clocks, or it emits a one-cycle non-maskable interrupt request. The counter then starts again from zero.

The reset logic outside this block uses `rst_by_wdog` to tell the block whether the current reset came from the watchdog. The block uses this to keep or clear its reset-cause flag.

Top module: `wdog_ctl`

## Requirements
- R1: The control byte at address 0x93 reads as {enable[7], action[6], cause[5], source[4:3], nmi_seen[2], period[1:0]}. After a reset with `rst_by_wdog`=0 it reads 0x00. A read of any other address returns 0x00.
- R2: A write with bit 7 set enables the watchdog. After that, writes with bit 7 clear leave the enable at 1 until the next reset.
- R3: With action=0, a time-out drives `rst_req` high for exactly four system clocks, starting in the cycle after the clock edge on which the terminal tick is counted.
- R4: With action=1, a time-out produces a single-cycle pulse on `nmi_req`, and `rst_req` stays low.
- R5: The cause flag (bit 5) is read-only and is set by every time-out under either action. A reset with `rst_by_wdog`=1 leaves it at 1, so the byte reads 0x20. A reset with `rst_by_wdog`=0 clears it.
- R6: The nmi_seen flag (bit 2) is set by an NMI time-out. It is read-only and is cleared on the edge where `rd_en` is high with address 0x93.
- R7: Period codes 00, 01, 10 and 11 give 2^P_LOG0, 2^P_LOG1, 2^P_LOG2 and 2^P_LOG3 ticks. The count restarts from zero after each time-out. If the period is shortened below the current count, the next tick produces a time-out.
- R8: Source code 00 counts every system clock. Code 01 counts rising edges of `rtc_in` after synchronization. Codes 10 and 11 count nothing.
- R9: Writing 0xA5 to address 0x94 and then 0x5A on the next write to that address clears the count. Any other byte disarms the key, and a new 0xA5 re-arms it.
- R10: While the enable is 0 the count stays at zero, and neither request output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_by_wdog | input | 1 | High during a reset that the watchdog caused |
| rtc_in | input | 1 | Asynchronous slow real-time-clock input |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; has a side effect on nmi_seen only |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| rst_req | output | 1 | Reset request, held for four clocks |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The bench measures exact cycle counts from the enabling or key write to the first request. An off-by-one terminal compare would show up as a period of 15 or 17 instead of 16. It tries to clear the enable, and it breaks the key sequence with a stray byte. A design with a writable enable would then fall silent, and a design that accepted a broken key would push the time-out back by the wrong amount. It also shortens the period below the running count and selects a reserved source. A design that compared for equality would wrap instead of firing on the next tick, and a design that decoded the reserved codes as active would still count. Finally, it resets with and without the watchdog-cause input, which exposes a cause flag that always clears or never clears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;

  localparam int B_EN    = 7;
  localparam int B_ACT   = 6;
  localparam int B_CAUSE = 5;
  localparam int B_SRC   = 3;
  localparam int B_NMI   = 2;
  localparam int B_PER   = 0;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'b00,
    SRC_RTC  = 2'b01,
    SRC_RSV2 = 2'b10,
    SRC_RSV3 = 2'b11
  } src_e;
endpackage

// File: rtl/wdog_rtc_tick.sv
module wdog_rtc_tick #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_in,
  output logic rtc_tick
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], rtc_in};
  end

  assign rtc_tick = sh_q[SYNC-1] & ~sh_q[SYNC];
endmodule

// File: rtl/wdog_kick_unlock.sv
module wdog_kick_unlock
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic       kick
);
  logic armed_q;

  assign kick = wr_stb && armed_q && (wdata == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_stb) armed_q <= !kick && (wdata == KEY_ARM);
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int P_LOG0 = 27,
  parameter int P_LOG1 = 25,
  parameter int P_LOG2 = 22,
  parameter int P_LOG3 = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       kick,
  input  logic [1:0] per_sel,
  output logic       expire
);
  localparam int CW = P_LOG0;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    case (per_sel)
      2'd0:    last = {CW{1'b1}};
      2'd1:    last = {CW{1'b1}} >> (CW - P_LOG1);
      2'd2:    last = {CW{1'b1}} >> (CW - P_LOG2);
      default: last = {CW{1'b1}} >> (CW - P_LOG3);
    endcase
  end

  assign expire = run && !kick && tick && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || kick)  cnt_q <= '0;
    else if (expire)        cnt_q <= '0;
    else if (tick)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR = 8'h93,
  parameter logic [7:0] KICK_ADDR = 8'h94,
  parameter int P_LOG0   = 27,
  parameter int P_LOG1   = 25,
  parameter int P_LOG2   = 22,
  parameter int P_LOG3   = 18,
  parameter int SYNC     = 2,
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_by_wdog,
  input  logic       rtc_in,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_req,
  output logic       nmi_req
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          en_q, act_q, rflag_q, nflag_q, nmi_q;
  logic [1:0]    src_q, per_q;
  logic [HW-1:0] hold_q;
  logic          ctrl_wr, ctrl_rd, kick_wr, kick, rtc_tick, tick, expire;
  logic          unused_w;

  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign ctrl_rd  = rd_en && (addr == CTRL_ADDR);
  assign kick_wr  = wr_en && (addr == KICK_ADDR);
  assign unused_w = ^{wdata[B_CAUSE], wdata[B_NMI]};

  wdog_rtc_tick #(.SYNC(SYNC)) u_rtc (
    .clk(clk), .rst_n(rst_n), .rtc_in(rtc_in), .rtc_tick(rtc_tick)
  );

  wdog_kick_unlock u_key (
    .clk(clk), .rst_n(rst_n), .wr_stb(kick_wr), .wdata(wdata), .kick(kick)
  );

  always_comb begin
    case (src_e'(src_q))
      SRC_SYS: tick = 1'b1;
      SRC_RTC: tick = rtc_tick;
      default: tick = 1'b0;
    endcase
  end

  wdog_count #(
    .P_LOG0(P_LOG0), .P_LOG1(P_LOG1), .P_LOG2(P_LOG2), .P_LOG3(P_LOG3)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick), .kick(kick),
    .per_sel(per_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      src_q   <= 2'b00;
      per_q   <= 2'b00;
      rflag_q <= rst_by_wdog;
      nflag_q <= 1'b0;
      nmi_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      nmi_q <= expire && act_q;
      if (expire && !act_q)  hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (expire) rflag_q <= 1'b1;
      if (expire && act_q) nflag_q <= 1'b1;
      else if (ctrl_rd)    nflag_q <= 1'b0;
      if (ctrl_wr) begin
        en_q  <= en_q | wdata[B_EN];
        act_q <= wdata[B_ACT];
        src_q <= wdata[B_SRC +: 2];
        per_q <= wdata[B_PER +: 2];
      end
    end
  end

  assign rst_req = (hold_q != '0);
  assign nmi_req = nmi_q;
  assign rdata   = (addr == CTRL_ADDR) ?
                   {en_q, act_q, rflag_q, src_q, nflag_q, per_q} : 8'h00;
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic rflag_q,
  input logic nmi_req,
  input logic rst_req
);
  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  assert_rst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req ##1 rst_req ##1 rst_req);

  assert_nmi_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  assert_nmi_no_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> !rst_req);

  assert_cause_on_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> rflag_q);

  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rflag_q |=> rflag_q);
endmodule

bind wdog_ctl wdog_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .rflag_q(rflag_q),
  .nmi_req(nmi_req), .rst_req(rst_req)
);

// File: tb/wdog_ctl_bench.sv
`timescale 1ns/1ps
module wdog_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0, rst_by_wdog = 1'b0, rtc_in = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic rst_req, nmi_req;

  int checks = 0, errors = 0;
  bit started = 0, rtc_run = 0;
  int rtc_ph = 0;

  always #4 clk = ~clk;

  wdog_ctl #(.P_LOG0(10), .P_LOG1(8), .P_LOG2(6), .P_LOG3(4)) u_wdog_ctl (
    .clk(clk), .rst_n(rst_n), .rst_by_wdog(rst_by_wdog), .rtc_in(rtc_in),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  // Behavioural reference state
  int m_en, m_act, m_cause, m_src, m_per, m_nflag, m_cnt, m_armed, m_hold, m_nmi;
  int rtc_hist[3];

  function automatic int period(int code);
    case (code)
      0: return 1 << 10;
      1: return 1 << 8;
      2: return 1 << 6;
      default: return 1 << 4;
    endcase
  endfunction

  function automatic int exp_rd();
    if (addr != 8'h93) return 0;
    return (m_en << 7) | (m_act << 6) | (m_cause << 5) | (m_src << 3) |
           (m_nflag << 2) | m_per;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_en = 0; m_act = 0; m_src = 0; m_per = 0; m_nflag = 0; m_cnt = 0;
      m_armed = 0; m_hold = 0; m_nmi = 0; m_cause = int'(rst_by_wdog);
      rtc_hist = '{0, 0, 0};
    end else begin
      int tick, fire, tout;
      tick = (m_src == 0) ? 1 : (m_src == 1) ? int'(rtc_hist[1] == 1 && rtc_hist[2] == 0) : 0;
      fire = int'(wr_en && addr == 8'h94 && m_armed == 1 && wdata == 8'h5A);
      tout = 0;
      if (m_en == 0 || fire == 1) m_cnt = 0;
      else if (tick == 1) begin
        if (m_cnt >= period(m_per) - 1) begin m_cnt = 0; tout = 1; end
        else m_cnt++;
      end
      m_nmi = int'(tout == 1 && m_act == 1);
      if (tout == 1 && m_act == 0) m_hold = 4;
      else if (m_hold > 0) m_hold--;
      if (tout == 1) m_cause = 1;
      if (tout == 1 && m_act == 1) m_nflag = 1;
      else if (rd_en && addr == 8'h93) m_nflag = 0;
      if (wr_en && addr == 8'h94) m_armed = (fire == 0 && wdata == 8'hA5) ? 1 : 0;
      if (wr_en && addr == 8'h93) begin
        m_en = m_en | int'(wdata[7]); m_act = int'(wdata[6]);
        m_src = int'(wdata[4:3]); m_per = int'(wdata[1:0]);
      end
      rtc_hist[2] = rtc_hist[1]; rtc_hist[1] = rtc_hist[0]; rtc_hist[0] = int'(rtc_in);
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) if (started) begin
    check("R3 rst_req vs model", int'(rst_req), int'(m_hold > 0));
    check("R4 nmi_req vs model", int'(nmi_req), m_nmi);
    check("R1 rdata vs model", int'(rdata), exp_rd());
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_pulse(logic [7:0] a);
    addr = a; rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(logic cause);
    rst_n = 1'b0; rst_by_wdog = cause;
    step(2);
    rst_n = 1'b1; rst_by_wdog = 1'b0;
    step(1);
  endtask

  task automatic wait_rst(output int n, input int lim);
    n = 0;
    while (!rst_req && n < lim) begin step(1); n++; end
  endtask

  // Slow clock source: period of six system clocks while running
  initial forever begin
    @(negedge clk); #1;
    if (rtc_run) begin rtc_ph = (rtc_ph + 1) % 6; rtc_in = (rtc_ph < 3); end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, m, seen;
    do_reset(1'b0);
    addr = 8'h93; #1;
    check("R1 reset value", int'(rdata), 8'h00);
    addr = 8'h40; #1;
    check("R1 other address reads zero", int'(rdata), 0);

    // R10: disabled counter stays silent
    wr(8'h93, 8'h03);
    wait_rst(n, 60);
    check("R10 no request while disabled", n, 60);

    // R3/R7: system clock, shortest period, reset action
    wr(8'h93, 8'h83);
    wait_rst(n, 100);
    check("R7 period code 11 ticks", n, 16);
    m = 0;
    while (rst_req && m < 20) begin step(1); m++; end
    check("R3 reset request length", m, 4);
    addr = 8'h93; #1;
    check("R5 cause flag after time-out", int'(rdata[5]), 1);

    // R2: attempt to disable
    wr(8'h93, 8'h03);
    addr = 8'h93; #1;
    check("R2 enable held after clearing write", int'(rdata[7]), 1);

    // R5: reset cause handling
    do_reset(1'b1);
    addr = 8'h93; #1;
    check("R5 watchdog reset keeps cause", int'(rdata), 8'h20);
    do_reset(1'b0);
    addr = 8'h93; #1;
    check("R5 external reset clears cause", int'(rdata), 8'h00);

    // R4/R6: NMI action, period code 10
    wr(8'h93, 8'hC2);
    n = 0; seen = 0;
    while (!nmi_req && n < 200) begin step(1); n++; seen |= int'(rst_req); end
    check("R7 period code 10 ticks", n, 64);
    check("R4 nmi pulse present", int'(nmi_req), 1);
    step(1);
    check("R4 nmi pulse one cycle", int'(nmi_req), 0);
    check("R4 no reset request in NMI mode", seen | int'(rst_req), 0);
    addr = 8'h93; #1;
    check("R6 nmi_seen set", int'(rdata[2]), 1);
    check("R5 cause set on NMI time-out", int'(rdata[5]), 1);
    rd_pulse(8'h93);
    addr = 8'h93; #1;
    check("R6 nmi_seen cleared by read", int'(rdata[2]), 0);

    // R9: key sequence
    do_reset(1'b0);
    wr(8'h93, 8'h81);
    step(200);
    wr(8'h94, 8'hA5);
    wr(8'h94, 8'h5A);
    wait_rst(n, 400);
    check("R9 valid key restarts count", n, 256);
    step(100);
    wr(8'h94, 8'hA5);
    wr(8'h94, 8'h33);
    wr(8'h94, 8'h5A);
    wait_rst(n, 400);
    check("R9 broken key ignored", n, 153);

    // R7: shorten period below running count
    do_reset(1'b0);
    wr(8'h93, 8'h80);
    step(40);
    wr(8'h93, 8'h83);
    wait_rst(n, 100);
    check("R7 shortened period fires next tick", n, 1);

    // R8: slow clock source
    do_reset(1'b0);
    rtc_run = 1;
    wr(8'h93, 8'h8B);
    wait_rst(n, 50);
    check("R8 slow source counts slower", n, 50);
    wait_rst(n, 150);
    check("R8 slow source eventually fires", int'(rst_req), 1);
    rtc_run = 0;

    // R8: reserved source code
    do_reset(1'b0);
    wr(8'h93, 8'h93);
    wait_rst(n, 120);
    check("R8 reserved source does not count", n, 120);

    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule